// File: doc/BRIEF.md
# Short I/O Slave Select and Acknowledge Timer

This block decides whether a bus cycle in the 16-bit short I/O address space belongs to a 1 KB target window, and answers that cycle. The upper six address bits are compared for equality with a 6-bit window setting, so the window can sit in any of 64 one-kilobyte slots. The address modifier must be a short-space code that the configuration accepts. The address strobe must be active.

A qualified cycle raises a registered select output, which the register file behind the window uses. Once a data strobe is active, a single 1 is shifted through a short shift register. The data acknowledge is driven low when that 1 reaches a tap fixed by a parameter. A long-word transfer is refused with a bus error in place of the acknowledge. Both responses are withdrawn as soon as the master releases both data strobes.

The window and modifier settings are plain inputs. A typical tie-off is window 0 with both short codes accepted.

Top module: `sio_slave_select`

## Requirements
- R1: While and after reset, before any access, card_sel_o is 0, dtack_no is 1 and berr_no is 1.
- R2: card_sel_o rises one clock edge after the edge that samples as_ni low with addr_i[15:10] equal to base_cfg_i and an accepted modifier. A different addr_i[15:10] never raises it.
- R3: Modifier code 6'h2D is always accepted. Code 6'h29 is accepted only when am_both_cfg_i is 1.
- R4: Any other modifier code leaves card_sel_o at 0, dtack_no at 1 and berr_no at 1.
- R5: With as_ni high, nothing responds, even if the address, modifier and strobes match.
- R6: With lword_ni high, dtack_no goes low on the ACK_TAP-th consecutive edge at which card_sel_o is already 1 and at least one strobe (ds0_ni or ds1_ni) is sampled low. Either strobe alone is enough.
- R7: With lword_ni low, berr_no goes low on the first such edge and dtack_no stays 1. The two are never low together.
- R8: The edge that samples both strobes high returns dtack_no and berr_no to 1 and clears the delay. The next access counts its delay from zero.
- R9: card_sel_o returns to 0 one edge after as_ni is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 15 | Address bits 15..1 |
| am_i | input | 6 | Address modifier |
| as_ni | input | 1 | Address strobe, active low |
| ds0_ni | input | 1 | Data strobe 0, active low |
| ds1_ni | input | 1 | Data strobe 1, active low |
| lword_ni | input | 1 | Long-word transfer, active low |
| write_ni | input | 1 | Transfer direction; has no effect on the response |
| base_cfg_i | input | 6 | Window slot compared with addr_i[15:10] |
| am_both_cfg_i | input | 1 | 1: accept 6'h2D and 6'h29; 0: 6'h2D only |
| card_sel_o | output | 1 | Window selected, registered |
| dtack_no | output | 1 | Data acknowledge, active low |
| berr_no | output | 1 | Bus error, active low |

## Verification
For the k-th cycle of an access, counted from 0 at the first driven cycle, the expected outputs are as follows. card_sel_o is due one edge after as_ni is driven (k ≥ 0). berr_no is due at k ≥ 1. dtack_no is due at k ≥ ACK_TAP. All three are due back at their idle values one edge after the release.

The driver queues one expected triple for each driven cycle. The monitor pops one triple at every falling edge, half a period after the rising edge that produced it, so each comparison lands in exactly the cycle worked out above.

Short holds, single strobes, refused modifiers, window misses and back-to-back accesses each run through the same per-cycle queue.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [5:0] AM_SHORT_SUP = 6'h2D;
  localparam logic [5:0] AM_SHORT_USR = 6'h29;
  localparam int unsigned TAP_MAX = 8;
endpackage

// File: rtl/sio_window_match.sv
module sio_window_match
  import sio_pkg::*;
#(
  parameter int unsigned SLOT_W = 6
) (
  input  logic [SLOT_W-1:0] addr_hi_i,
  input  logic [SLOT_W-1:0] base_cfg_i,
  input  logic [5:0]        am_i,
  input  logic              am_both_cfg_i,
  output logic              hit_o
);
  logic am_ok;

  always_comb begin
    am_ok = (am_i == AM_SHORT_SUP) || (am_both_cfg_i && (am_i == AM_SHORT_USR));
    hit_o = am_ok && (addr_hi_i == base_cfg_i);
  end
endmodule

// File: rtl/sio_ack_timer.sv
module sio_ack_timer
  import sio_pkg::*;
#(
  parameter int unsigned ACK_TAP = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic ds_act_i,
  input  logic lword_i,
  output logic dtack_no,
  output logic berr_no
);
  localparam int unsigned SH_W = ACK_TAP;

  logic [SH_W-1:0] sh_q;
  logic            berr_q;

  // a 1 travels up the chain while the strobe is held; cleared on release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      berr_q <= 1'b0;
    end else if (!sel_i || !ds_act_i) begin
      sh_q   <= '0;
      berr_q <= 1'b0;
    end else if (lword_i) begin
      berr_q <= 1'b1;
    end else begin
      sh_q <= (sh_q << 1) | SH_W'(1);
    end
  end

  assign dtack_no = !sh_q[SH_W-1];
  assign berr_no  = !berr_q;

  initial begin
    if (ACK_TAP < 1 || ACK_TAP > TAP_MAX) $error("ACK_TAP out of range");
  end

  // R7: the two responses are exclusive
  a_r7_resp_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dtack_no && !berr_no));
  // R8: both strobes released -> responses withdrawn next edge
  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_act_i |=> (dtack_no && berr_no));
  // R6: acknowledge only follows a selected cycle
  a_r6_ack_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dtack_no |-> $past(sel_i && ds_act_i && !lword_i));
  // R7: bus error only follows a long-word request
  a_r7_berr_needs_lword: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !berr_no |-> $past(lword_i && sel_i));
endmodule

// File: rtl/sio_slave_select.sv
module sio_slave_select
  import sio_pkg::*;
#(
  parameter int unsigned ACK_TAP = 3,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned WIN_W   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic [5:0]        am_i,
  input  logic              as_ni,
  input  logic              ds0_ni,
  input  logic              ds1_ni,
  input  logic              lword_ni,
  input  logic              write_ni,
  input  logic [ADDR_W-WIN_W-1:0] base_cfg_i,
  input  logic              am_both_cfg_i,
  output logic              card_sel_o,
  output logic              dtack_no,
  output logic              berr_no
);
  localparam int unsigned SLOT_W = ADDR_W - WIN_W;

  logic hit;
  logic sel_q;
  logic ds_act;
  logic unused_dir;

  assign ds_act     = !ds0_ni || !ds1_ni;
  assign unused_dir = write_ni;

  sio_window_match #(.SLOT_W(SLOT_W)) u_match (
    .addr_hi_i     (addr_i[ADDR_W-1:WIN_W]),
    .base_cfg_i    (base_cfg_i),
    .am_i          (am_i),
    .am_both_cfg_i (am_both_cfg_i),
    .hit_o         (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= hit && !as_ni;
  end

  assign card_sel_o = sel_q;

  sio_ack_timer #(.ACK_TAP(ACK_TAP)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_q),
    .ds_act_i (ds_act),
    .lword_i  (!lword_ni),
    .dtack_no (dtack_no),
    .berr_no  (berr_no)
  );

  // R5 / R9: address strobe high -> deselected next edge
  a_r9_as_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |=> !card_sel_o);
  // R4: a selected cycle always carried one of the two short codes
  a_r4_am_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_sel_o |-> ($past(am_i) == AM_SHORT_SUP || $past(am_i) == AM_SHORT_USR));
  // R3: the user code needs the configuration bit
  a_r3_usr_needs_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_sel_o && $past(am_i) == AM_SHORT_USR) |-> $past(am_both_cfg_i));
  // R2: select implies the window slot matched
  a_r2_slot_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_sel_o |-> ($past(addr_i[ADDR_W-1:WIN_W]) == $past(base_cfg_i)));
endmodule

// File: tb/sio_slave_select_bench.sv
module sio_slave_select_bench;
  localparam int unsigned TAP = 3;
  localparam int WDOG = 20000;

  typedef struct {
    logic  sel;
    logic  dtack_n;
    logic  berr_n;
    string tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:1] addr_i = '0;
  logic [5:0]  am_i = '0;
  logic        as_ni = 1'b1, ds0_ni = 1'b1, ds1_ni = 1'b1;
  logic        lword_ni = 1'b1, write_ni = 1'b1;
  logic [5:0]  base_cfg_i = '0;
  logic        am_both_cfg_i = 1'b1;
  logic        card_sel_o, dtack_no, berr_no;

  int   n_chk = 0, n_fail = 0;
  exp_t q[$];
  bit   done = 0;

  always #2 clk_i = ~clk_i;

  sio_slave_select #(.ACK_TAP(TAP)) u_sio_slave_select (
    .clk_i, .rst_ni, .addr_i, .am_i, .as_ni, .ds0_ni, .ds1_ni,
    .lword_ni, .write_ni, .base_cfg_i, .am_both_cfg_i,
    .card_sel_o, .dtack_no, .berr_no
  );

  // monitor: one expected triple per falling edge
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (card_sel_o !== e.sel || dtack_no !== e.dtack_n || berr_no !== e.berr_n) begin
        n_fail++;
        $display("FAIL %s: sel/dtack_n/berr_n actual %b%b%b expected %b%b%b",
                 e.tag, card_sel_o, dtack_no, berr_no, e.sel, e.dtack_n, e.berr_n);
      end
    end
  end

  task automatic push(input logic s, input logic d, input logic b, input string tag);
    exp_t e;
    e.sel = s; e.dtack_n = d; e.berr_n = b; e.tag = tag;
    q.push_back(e);
  endtask

  // driver: hold the access for 'hold' cycles, then release for one cycle
  task automatic access(input logic [5:0] slot, input logic [5:0] am, input logic lw,
                        input logic [1:0] ds_on, input logic as_on, input int hold,
                        input logic hit, input string tag);
    logic go;
    go = hit && as_on;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk_i); #1;
      addr_i   = {slot, 9'h0A5};
      am_i     = am;
      lword_ni = !lw;
      write_ni = k[0];
      as_ni    = !as_on;
      ds0_ni   = !ds_on[0];
      ds1_ni   = !ds_on[1];
      push(go,
           !(go && ds_on != 2'b00 && !lw && k >= TAP),
           !(go && ds_on != 2'b00 && lw && k >= 1), tag);
    end
    @(negedge clk_i); #1;
    as_ni = 1'b1; ds0_ni = 1'b1; ds1_ni = 1'b1; lword_ni = 1'b1;
    push(1'b0, 1'b1, 1'b1, tag);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (card_sel_o !== 1'b0 || dtack_no !== 1'b1 || berr_no !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset: actual %b%b%b expected 011", card_sel_o, dtack_no, berr_no);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R6: supervisory code, window 0, both strobes
    access(6'h00, 6'h2D, 1'b0, 2'b11, 1'b1, 6, 1'b1, "R2_R6 sup hit");
    // R3: user code accepted with config 1
    access(6'h00, 6'h29, 1'b0, 2'b11, 1'b1, 5, 1'b1, "R3 usr accepted");
    drain();
    am_both_cfg_i = 1'b0;
    // R3: user code refused with config 0; supervisory still fine
    access(6'h00, 6'h29, 1'b0, 2'b11, 1'b1, 5, 1'b0, "R3 usr refused");
    access(6'h00, 6'h2D, 1'b0, 2'b01, 1'b1, 5, 1'b1, "R3_R6 sup only ds0");
    drain();
    am_both_cfg_i = 1'b1;
    // R4: other modifier codes ignored
    access(6'h00, 6'h3D, 1'b0, 2'b11, 1'b1, 5, 1'b0, "R4 other am 3D");
    access(6'h00, 6'h39, 1'b1, 2'b11, 1'b1, 4, 1'b0, "R4 other am 39 lword");
    drain();
    base_cfg_i = 6'h05;
    // R2: slot miss and slot hit
    access(6'h06, 6'h2D, 1'b0, 2'b11, 1'b1, 5, 1'b0, "R2 slot miss");
    access(6'h05, 6'h2D, 1'b0, 2'b10, 1'b1, 5, 1'b1, "R2_R6 slot 5 ds1");
    drain();
    base_cfg_i = 6'h3F;
    access(6'h3F, 6'h29, 1'b0, 2'b11, 1'b1, 4, 1'b1, "R2 slot 3F");
    // R7: long word -> bus error
    access(6'h3F, 6'h2D, 1'b1, 2'b11, 1'b1, 5, 1'b1, "R7 lword berr");
    // R5: strobes without address strobe
    access(6'h3F, 6'h2D, 1'b0, 2'b11, 1'b0, 5, 1'b1, "R5 no as");
    // R8: release before tap, then back-to-back restart
    access(6'h3F, 6'h2D, 1'b0, 2'b11, 1'b1, 2, 1'b1, "R8 short hold");
    access(6'h3F, 6'h2D, 1'b0, 2'b11, 1'b1, 4, 1'b1, "R8_R9 restart");
    access(6'h3F, 6'h2D, 1'b0, 2'b00, 1'b1, 4, 1'b1, "R6 sel no strobe");
    drain();
    done = 1;
    report();
  end
endmodule